// File: doc/BRIEF.md
# Sliced Control/Status Register Bank

A register bank that sits on a simple local register bus made of an address, a write enable, write data and read data. The bank claims the part of the address space whose upper bits, from bit 9 upward, equal its bank number parameter. The nine low bits pick one data-width slot inside the bank. The bank holds a parameterised list of registers. Each register is one of three kinds: a fixed constant, a live status value supplied by surrounding logic, or a storage register that the processor writes and reads back and that logic can use.

The slots are laid out from slot 0 in register-list order. A register wider than the bus width takes as many adjacent slots as it needs, and its most significant slice sits at the lowest slot. A write completes on the clock edge where it is presented. Read data is registered and appears one cycle after the address. A storage register can also be loaded from the logic side with an override strobe. Each storage register gives a one-cycle pulse when its last slot is written, so logic can pick up a multi-slot update as a whole.

Top module: `regbank_top`

## Requirements
- R1: The bank responds only when `bus_addr[AW-1:9]` equals `BANK_ID`. A read of any other bank returns zero on the next cycle, and a write to any other bank changes no register.
- R2: `bus_rdata` is registered. It shows the addressed slot in the cycle after the address is presented. A slot beyond the last mapped slot of the bank reads as zero.
- R3: Slots are assigned from slot 0 in register order. Register k takes ceil(width/DW) consecutive slots. Slot base+j holds bits [(N-1-j)*DW +: DW] of the zero-padded value, so the most significant slice comes first. Bits above the register width read as zero.
- R4: A constant register always reads its `REG_INIT` value, and writes to its slots have no effect.
- R5: A status register reads the `sts_in` value present in the cycle its address is presented. Writes to its slots have no effect.
- R6: A storage register resets to its `REG_INIT` value. A write replaces exactly the addressed slice on that clock edge. The full value is visible on `store_q` and can be read back over the bus. It holds when neither a write nor an override targets it.
- R7: When `ovr_stb[k]` is high and no bus write hits register k, storage register k loads `ovr_val` (truncated to its width) on that edge.
- R8: When a bus write hits any slot of storage register k in the same cycle as `ovr_stb[k]`, the bus write is applied and the override is dropped.
- R9: `store_wr[k]` is high for one cycle, in the cycle after a write to the last (least significant) slot of storage register k. Writes to its other slots do not raise it.
- R10: With AW=14, DW=8 and bank 4, slot 5 sits at local address 0x805 (CPU byte offset 0x2014 for word-aligned access). It returns the middle byte of the 24-bit register at slots 4 to 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW | Local bus address (bank number in bits AW-1..9, slot in 8..0) |
| bus_we | input | 1 | Write enable for the addressed slot |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| sts_in | input | NUM_REGS*MAXW | Status values, MAXW bits per register, used by status registers |
| ovr_stb | input | NUM_REGS | Logic-side override strobe per register |
| ovr_val | input | NUM_REGS*MAXW | Logic-side override value per register |
| store_q | output | NUM_REGS*MAXW | Current storage register contents, zero for other kinds |
| store_wr | output | NUM_REGS | One-cycle pulse after the last slot of a storage register is written |

## Verification
A wrong stored value shows up on `store_q` on the very next edge. It also shows in the read data one cycle after its slot is addressed. Those two views are compared against a behavioural model on every clock. A slicing or base-offset error shows up as a wrong byte in the cycle after a read of the affected slot. Wrong bank decode shows as nonzero read data, or as a register that changes one edge after a foreign write. A priority error between bus write and override shows in `store_q` in the cycle right after the collision.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  typedef enum logic [1:0] {
    RK_CONST  = 2'd0,
    RK_STATUS = 2'd1,
    RK_STORE  = 2'd2
  } rkind_e;
endpackage

// File: rtl/regbank_decode.sv
module regbank_decode #(
  parameter int AW      = 14,
  parameter int SLOTW   = 9,
  parameter int BANK_ID = 4
) (
  input  logic [AW-1:0]    addr,
  output logic             hit,
  output logic [SLOTW-1:0] slot
);
  localparam int IDW = AW - SLOTW;

  assign hit  = (addr[AW-1:SLOTW] == IDW'(BANK_ID));
  assign slot = addr[SLOTW-1:0];
endmodule

// File: rtl/regbank_reg.sv
module regbank_reg
  import regbank_pkg::*;
#(
  parameter int              W     = 16,
  parameter int              DW    = 8,
  parameter int              MAXW  = 64,
  parameter int              SLOTW = 9,
  parameter rkind_e          KIND  = RK_STORE,
  parameter logic [MAXW-1:0] INIT  = '0,
  parameter int              BASE  = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic             we,
  input  logic [SLOTW-1:0] slot,
  input  logic [DW-1:0]    wdata,
  input  logic [MAXW-1:0]  sts,
  input  logic             ovr_stb,
  input  logic [MAXW-1:0]  ovr_val,
  output logic [MAXW-1:0]  val_q,
  output logic             wr_pulse,
  output logic [DW-1:0]    rd_slice
);
  localparam int N  = (W + DW - 1) / DW;
  localparam int PW = N * DW;

  logic [PW-1:0] view;

  generate
    if (KIND == RK_STORE) begin : g_store
      logic [W-1:0]  q;
      logic [PW-1:0] nxt;
      logic [N-1:0]  sel;
      logic          wr_any;
      logic          unused_pad;

      always_comb begin
        nxt = PW'(q);
        for (int j = 0; j < N; j++) begin
          sel[j] = hit && we && (slot == SLOTW'(BASE + j));
          if (sel[j]) nxt[(N-1-j)*DW +: DW] = wdata;
        end
        wr_any = |sel;
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          q        <= INIT[W-1:0];
          wr_pulse <= 1'b0;
        end else begin
          if (wr_any)       q <= nxt[W-1:0];
          else if (ovr_stb) q <= ovr_val[W-1:0];
          wr_pulse <= sel[N-1];
        end
      end

      assign view       = PW'(q);
      assign val_q      = MAXW'(q);
      assign unused_pad = ^{nxt, sts};
    end else if (KIND == RK_STATUS) begin : g_status
      logic unused_st;
      assign view      = PW'(sts[W-1:0]);
      assign val_q     = '0;
      assign wr_pulse  = 1'b0;
      assign unused_st = ^{clk, rst, hit, we, wdata, ovr_stb, ovr_val, sts};
    end else begin : g_const
      logic unused_cn;
      assign view      = PW'(INIT[W-1:0]);
      assign val_q     = '0;
      assign wr_pulse  = 1'b0;
      assign unused_cn = ^{clk, rst, hit, we, wdata, ovr_stb, ovr_val, sts};
    end
  endgenerate

  always_comb begin
    rd_slice = '0;
    for (int j = 0; j < N; j++) begin
      if (slot == SLOTW'(BASE + j)) rd_slice = view[(N-1-j)*DW +: DW];
    end
  end
endmodule

// File: rtl/regbank_rdmux.sv
module regbank_rdmux #(
  parameter int DW       = 8,
  parameter int NUM_REGS = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   hit,
  input  logic [NUM_REGS*DW-1:0] slices,
  output logic [DW-1:0]          rdata
);
  logic [DW-1:0] merged;

  always_comb begin
    merged = '0;
    for (int k = 0; k < NUM_REGS; k++) merged = merged | slices[k*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (rst)      rdata <= '0;
    else if (hit) rdata <= merged;
    else          rdata <= '0;
  end
endmodule

// File: rtl/regbank_top.sv
module regbank_top
  import regbank_pkg::*;
#(
  parameter int              AW       = 14,
  parameter int              DW       = 8,
  parameter int              SLOTW    = 9,
  parameter int              BANK_ID  = 4,
  parameter int              NUM_REGS = 4,
  parameter int              MAXW     = 64,
  parameter int              REG_W    [NUM_REGS] = '{16, 12, 24, 8},
  parameter rkind_e          REG_KIND [NUM_REGS] = '{RK_CONST, RK_STATUS, RK_STORE, RK_STORE},
  parameter logic [MAXW-1:0] REG_INIT [NUM_REGS] = '{64'hBEEF, 64'h0, 64'h123456, 64'h5A}
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [AW-1:0]            bus_addr,
  input  logic                     bus_we,
  input  logic [DW-1:0]            bus_wdata,
  output logic [DW-1:0]            bus_rdata,
  input  logic [NUM_REGS*MAXW-1:0] sts_in,
  input  logic [NUM_REGS-1:0]      ovr_stb,
  input  logic [NUM_REGS*MAXW-1:0] ovr_val,
  output logic [NUM_REGS*MAXW-1:0] store_q,
  output logic [NUM_REGS-1:0]      store_wr
);
  function automatic int slot_base(int idx);
    int s;
    s = 0;
    for (int k = 0; k < idx; k++) s += (REG_W[k] + DW - 1) / DW;
    return s;
  endfunction

  localparam int TOTAL_SLOTS = slot_base(NUM_REGS);

  generate
    if (DW != 8 && DW != 16 && DW != 32 && DW != 64) begin : g_bad_dw
      $fatal(1, "regbank_top: DW must be 8, 16, 32 or 64");
    end
    if (TOTAL_SLOTS > (1 << SLOTW)) begin : g_bad_fit
      $fatal(1, "regbank_top: registers exceed the slot space");
    end
  endgenerate

  logic                   hit;
  logic [SLOTW-1:0]       slot;
  logic [NUM_REGS*DW-1:0] slices;

  regbank_decode #(.AW(AW), .SLOTW(SLOTW), .BANK_ID(BANK_ID)) u_dec (
    .addr (bus_addr),
    .hit  (hit),
    .slot (slot)
  );

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      if (REG_W[i] < 1 || REG_W[i] > MAXW) begin : g_bad_w
        $fatal(1, "regbank_top: register width out of range");
      end
      regbank_reg #(
        .W     (REG_W[i]),
        .DW    (DW),
        .MAXW  (MAXW),
        .SLOTW (SLOTW),
        .KIND  (REG_KIND[i]),
        .INIT  (REG_INIT[i]),
        .BASE  (slot_base(i))
      ) u_reg (
        .clk      (clk),
        .rst      (rst),
        .hit      (hit),
        .we       (bus_we),
        .slot     (slot),
        .wdata    (bus_wdata),
        .sts      (sts_in[i*MAXW +: MAXW]),
        .ovr_stb  (ovr_stb[i]),
        .ovr_val  (ovr_val[i*MAXW +: MAXW]),
        .val_q    (store_q[i*MAXW +: MAXW]),
        .wr_pulse (store_wr[i]),
        .rd_slice (slices[i*DW +: DW])
      );
    end
  endgenerate

  regbank_rdmux #(.DW(DW), .NUM_REGS(NUM_REGS)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .hit    (hit),
    .slices (slices),
    .rdata  (bus_rdata)
  );
endmodule

// File: rtl/regbank_chk.sv
module regbank_chk
  import regbank_pkg::*;
#(
  parameter int              AW       = 14,
  parameter int              DW       = 8,
  parameter int              SLOTW    = 9,
  parameter int              BANK_ID  = 4,
  parameter int              NUM_REGS = 4,
  parameter int              MAXW     = 64,
  parameter int              REG_W    [NUM_REGS] = '{16, 12, 24, 8},
  parameter rkind_e          REG_KIND [NUM_REGS] = '{RK_CONST, RK_STATUS, RK_STORE, RK_STORE}
) (
  input logic                     clk,
  input logic                     rst,
  input logic [AW-1:0]            bus_addr,
  input logic                     bus_we,
  input logic [DW-1:0]            bus_wdata,
  input logic [DW-1:0]            bus_rdata,
  input logic [NUM_REGS-1:0]      ovr_stb,
  input logic [NUM_REGS*MAXW-1:0] ovr_val,
  input logic [NUM_REGS*MAXW-1:0] store_q,
  input logic [NUM_REGS-1:0]      store_wr
);
  function automatic int slot_base(int idx);
    int s;
    s = 0;
    for (int k = 0; k < idx; k++) s += (REG_W[k] + DW - 1) / DW;
    return s;
  endfunction

  localparam int TOTAL = slot_base(NUM_REGS);

  logic in_bank;
  int   slot_i;
  assign in_bank = (bus_addr[AW-1:SLOTW] == (AW-SLOTW)'(BANK_ID));
  assign slot_i  = int'(bus_addr[SLOTW-1:0]);

  assert_miss_reads_zero_R1: assert property (@(posedge clk) disable iff (rst)
    !in_bank |=> bus_rdata == '0);

  assert_miss_write_ignored_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !in_bank && ovr_stb == '0) |=> $stable(store_q));

  assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (in_bank && slot_i >= TOTAL) |=> bus_rdata == '0);

  assert_idle_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (!bus_we && ovr_stb == '0) |=> $stable(store_q));

  assert_pulse_has_cause_R9: assert property (@(posedge clk) disable iff (rst)
    (store_wr != '0) |-> $past(bus_we));

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_st
      if (REG_KIND[i] == RK_STORE) begin : g_on
        localparam int N = (REG_W[i] + DW - 1) / DW;
        localparam int LAST = slot_base(i) + N - 1;
        localparam logic [DW-1:0] LSMASK =
          (REG_W[i] >= DW) ? {DW{1'b1}} : DW'((64'd1 << REG_W[i]) - 64'd1);

        assert_override_loads_R7: assert property (@(posedge clk) disable iff (rst)
          (ovr_stb[i] && !bus_we) |=>
            store_q[i*MAXW +: MAXW] == MAXW'($past(ovr_val[i*MAXW +: REG_W[i]])));

        assert_cpu_beats_override_R8: assert property (@(posedge clk) disable iff (rst)
          (bus_we && in_bank && slot_i == LAST) |=>
            store_q[i*MAXW +: DW] == ($past(bus_wdata) & LSMASK));
      end
    end
  endgenerate
endmodule

bind regbank_top regbank_chk #(
  .AW(AW), .DW(DW), .SLOTW(SLOTW), .BANK_ID(BANK_ID), .NUM_REGS(NUM_REGS),
  .MAXW(MAXW), .REG_W(REG_W), .REG_KIND(REG_KIND)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ovr_stb(ovr_stb),
  .ovr_val(ovr_val), .store_q(store_q), .store_wr(store_wr)
);

// File: tb/sim_regbank_top.sv
`timescale 1ns/1ps
module sim_regbank_top;
  localparam int NR = 4;
  localparam int MW = 64;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [13:0]     bus_addr = '0;
  logic            bus_we = 1'b0;
  logic [7:0]      bus_wdata = '0;
  logic [7:0]      bus_rdata;
  logic [NR*MW-1:0] sts_in = '0;
  logic [NR-1:0]   ovr_stb = '0;
  logic [NR*MW-1:0] ovr_val = '0;
  logic [NR*MW-1:0] store_q;
  logic [NR-1:0]   store_wr;

  regbank_top u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sts_in(sts_in),
    .ovr_stb(ovr_stb), .ovr_val(ovr_val), .store_q(store_q), .store_wr(store_wr)
  );

  always #10 clk = ~clk;

  // reference description of the register list: width, kind (0 const, 1 status, 2 storage), init
  int          rw [NR] = '{16, 12, 24, 8};
  int          rk [NR] = '{0, 1, 2, 2};
  logic [63:0] ri [NR] = '{64'hBEEF, 64'h0, 64'h123456, 64'h5A};

  logic [63:0] m_store [NR];
  logic [7:0]  m_rd;
  logic [NR-1:0] m_pulse;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R6";
  bit    done = 0;

  function automatic logic [63:0] wmask(int w);
    return (w >= 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic logic [63:0] cur_val(int i);
    if (rk[i] == 0) return ri[i] & wmask(rw[i]);
    if (rk[i] == 1) return sts_in[i*MW +: MW] & wmask(rw[i]);
    return m_store[i];
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // behavioural model, one step per rising edge
  always @(posedge clk) begin
    int base, n, off, sh;
    bit wrote [NR];
    logic [7:0] rd;
    logic [NR-1:0] pl;
    if (rst) begin
      for (int i = 0; i < NR; i++) m_store[i] = (rk[i] == 2) ? (ri[i] & wmask(rw[i])) : 64'd0;
      m_rd = '0;
      m_pulse = '0;
    end else begin
      rd = '0;
      pl = '0;
      base = 0;
      for (int i = 0; i < NR; i++) begin
        wrote[i] = 0;
        n = (rw[i] + 7) / 8;
        if ((bus_addr >> 9) == 4 && int'(bus_addr[8:0]) >= base && int'(bus_addr[8:0]) < base + n) begin
          off = int'(bus_addr[8:0]) - base;
          sh = 8 * (n - 1 - off);
          rd = 8'(cur_val(i) >> sh);
          if (bus_we && rk[i] == 2) begin
            m_store[i] = ((m_store[i] & ~(64'hFF << sh)) | (64'(bus_wdata) << sh)) & wmask(rw[i]);
            wrote[i] = 1;
            if (off == n - 1) pl[i] = 1'b1;
          end
        end
        base += n;
      end
      for (int i = 0; i < NR; i++)
        if (rk[i] == 2 && !wrote[i] && ovr_stb[i])
          m_store[i] = ovr_val[i*MW +: MW] & wmask(rw[i]);
      m_rd = rd;
      m_pulse = pl;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(bus_rdata == m_rd, cur_req, "bus_rdata", 64'(bus_rdata), 64'(m_rd));
      for (int i = 0; i < NR; i++) begin
        chk(store_q[i*MW +: MW] == m_store[i], cur_req, "store_q", store_q[i*MW +: MW], m_store[i]);
      end
      chk(store_wr == m_pulse, cur_req, "store_wr", 64'(store_wr), 64'(m_pulse));
    end
  end

  task automatic drive(logic [13:0] a, bit we, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = we; bus_wdata = d;
  endtask

  task automatic idle();
    @(negedge clk);
    bus_we = 0; ovr_stb = '0;
  endtask

  task automatic rd_expect(logic [13:0] a, logic [7:0] exp, string req);
    drive(a, 0, 8'h00);
    @(negedge clk);
    chk(bus_rdata == exp, req, "directed read", 64'(bus_rdata), 64'(exp));
  endtask

  function automatic logic [13:0] la(int bank, int slot);
    return 14'((bank << 9) | slot);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // reset state of storage registers (R6)
    chk(store_q[2*MW +: MW] == 64'h123456, "R6", "reset value", store_q[2*MW +: MW], 64'h123456);
    chk(store_q[3*MW +: MW] == 64'h5A, "R6", "reset value", store_q[3*MW +: MW], 64'h5A);

    cur_req = "R4";
    rd_expect(la(4, 0), 8'hBE, "R4");
    rd_expect(la(4, 1), 8'hEF, "R4");
    drive(la(4, 0), 1, 8'h00);
    drive(la(4, 1), 1, 8'h11);
    rd_expect(la(4, 0), 8'hBE, "R4");
    rd_expect(la(4, 1), 8'hEF, "R4");

    cur_req = "R5";
    sts_in[1*MW +: MW] = 64'hFFFF_FABC;
    rd_expect(la(4, 2), 8'h0A, "R5");
    rd_expect(la(4, 3), 8'hBC, "R5");
    drive(la(4, 2), 1, 8'h55);
    sts_in[1*MW +: MW] = 64'h123;
    rd_expect(la(4, 3), 8'h23, "R5");

    cur_req = "R10";
    chk(la(4, 5) == 14'h805, "R10", "address form", 64'(la(4, 5)), 64'h805);
    chk((32'(la(4, 5)) << 2) == 32'h2014, "R10", "byte offset", 64'(32'(la(4, 5)) << 2), 64'h2014);
    rd_expect(14'h805, 8'h34, "R10");

    cur_req = "R3";
    rd_expect(la(4, 4), 8'h12, "R3");
    rd_expect(la(4, 6), 8'h56, "R3");
    rd_expect(la(4, 7), 8'h5A, "R3");

    cur_req = "R9";
    drive(la(4, 4), 1, 8'hA1);
    drive(la(4, 5), 1, 8'hB2);
    idle();
    chk(store_wr == 4'b0000, "R9", "no pulse mid-update", 64'(store_wr), 64'h0);
    drive(la(4, 6), 1, 8'hC3);
    idle();
    chk(store_wr == 4'b0100, "R9", "pulse after last slice", 64'(store_wr), 64'h4);
    chk(store_q[2*MW +: MW] == 64'hA1B2C3, "R6", "sliced write", store_q[2*MW +: MW], 64'hA1B2C3);
    @(negedge clk);
    chk(store_wr == 4'b0000, "R9", "pulse one cycle", 64'(store_wr), 64'h0);

    cur_req = "R1";
    drive(la(5, 7), 1, 8'hEE);
    drive(la(0, 4), 1, 8'hEE);
    idle();
    chk(store_q[3*MW +: MW] == 64'h5A, "R1", "foreign write", store_q[3*MW +: MW], 64'h5A);
    rd_expect(la(5, 0), 8'h00, "R1");
    rd_expect(la(31, 4), 8'h00, "R1");

    cur_req = "R2";
    rd_expect(la(4, 8), 8'h00, "R2");
    rd_expect(la(4, 511), 8'h00, "R2");

    cur_req = "R7";
    @(negedge clk);
    bus_we = 0; ovr_stb = 4'b1000; ovr_val[3*MW +: MW] = 64'hFFC3;
    idle();
    chk(store_q[3*MW +: MW] == 64'hC3, "R7", "override load", store_q[3*MW +: MW], 64'hC3);

    cur_req = "R8";
    @(negedge clk);
    bus_addr = la(4, 7); bus_we = 1; bus_wdata = 8'h77;
    ovr_stb = 4'b1100; ovr_val[3*MW +: MW] = 64'h99; ovr_val[2*MW +: MW] = 64'h000FED;
    idle();
    chk(store_q[3*MW +: MW] == 64'h77, "R8", "write beats override", store_q[3*MW +: MW], 64'h77);
    chk(store_q[2*MW +: MW] == 64'h000FED, "R7", "override other reg", store_q[2*MW +: MW], 64'h000FED);
    @(negedge clk);
    bus_addr = la(4, 4); bus_we = 1; bus_wdata = 8'h44;
    ovr_stb = 4'b0100; ovr_val[2*MW +: MW] = 64'h777777;
    idle();
    chk(store_q[2*MW +: MW] == 64'h440FED, "R8", "override dropped", store_q[2*MW +: MW], 64'h440FED);

    cur_req = "R1 R2 R5 R6 R7 R8 R9";
    for (int c = 0; c < 400; c++) begin
      int pick;
      @(negedge clk);
      pick = int'($urandom % 6);
      bus_addr  = la((pick == 5) ? 3 : ((pick == 4) ? 0 : 4), int'($urandom % 10));
      bus_we    = ($urandom % 2) == 1;
      bus_wdata = 8'($urandom);
      ovr_stb   = 4'($urandom) & 4'($urandom);
      for (int i = 0; i < NR; i++) begin
        ovr_val[i*MW +: MW] = {32'($urandom), 32'($urandom)};
        sts_in[i*MW +: MW]  = {32'($urandom), 32'($urandom)};
      end
    end
    idle();
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule